// File: doc/BRIEF.md
# GPIO Pin Input Conditioning and Interrupt Bank

This block conditions the inputs of a bank of general-purpose pins and turns them into interrupts. Every pin runs through two resynchronizing stages in series; each stage is set on its own to pass the signal straight through, to capture on the falling clock edge, or to capture on the rising clock edge. The conditioned level goes to a per-pin detector. The detector can be off, can trigger on edges (rising, falling or either), or can trigger on a low or a high level. Each detection sets a sticky bit in a status vector.

Software can change the status vector in three ways: it can overwrite the whole vector, it can set chosen bits by writing ones, and it can clear chosen bits by writing ones. Each pin has a 13-bit configuration word. In that word, two enable bits steer the pin's status onto a maskable interrupt vector and onto a non-maskable interrupt vector. Each vector is reduced to a single request line. A separate enable bit lets the pin raise a wakeup request. The block also presents the conditioned levels and the raw detections of the current cycle, before latching.

The detector keeps only one register per pin, the previously conditioned sample, and it has no sequencing states. Configuration is written one pin at a time through an index and can be read back through the same index.

Top module: `gpio_irq_bank`

## Requirements
- R1: The bank serves 30 pins on bits 29:0 of the 32-bit level, raw, status, maskable and non-maskable vectors. Bits 31:30 of these vectors always read 0, even when software writes ones there.
- R2: Each synchronizer stage has a 2-bit mode. Mode 0 passes the signal combinationally, mode 1 captures it on the falling clock edge, and modes 2 and 3 capture it on the rising clock edge. The first stage's mode sits in config bits 1:0, and its output feeds the second stage, whose mode sits in bits 3:2.
- R3: The trigger code sits in config bits 6:4. Codes 1, 2 and 3 detect a rising, a falling or any change of the conditioned level, compared with the sample taken one rising edge earlier. A level that is held steady produces no further detection.
- R4: Code 4 (level low) and code 5 (level high) detect in every cycle in which the level holds. A status bit that software clears therefore comes back while the level persists.
- R5: Code 0 and the unused codes 6 and 7 never detect.
- R6: The raw output shows the current detections combinationally, before they are latched.
- R7: A direct write loads the status vector. When several writes happen in the same cycle, the block applies the direct write first, then the set alias, then the clear alias, and finally the hardware detections.
- R8: The set alias sets the bits written as 1 and leaves the bits written as 0 unchanged.
- R9: The clear alias clears the bits written as 1 and leaves the bits written as 0 unchanged.
- R10: If a detection and a clear of the same bit happen in the same cycle, the bit ends up set.
- R11: Config bit 8 enables the pin onto the maskable vector, and bit 9 enables it onto the non-maskable vector. Each vector is the status ANDed with its enables, and each request line is the OR of its vector. Config bits 12:10 have no effect.
- R12: Config bit 7 enables the pin for wakeup. The wakeup request is the OR of the status bits whose wakeup is enabled.
- R13: Reset clears every configuration word, every status bit, every synchronizer register and every previous-sample register.
- R14: A configuration write stores the 13-bit word for the pin at the index. The readback shows the word at the index, and an index of 30 or above reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | 30 | Raw pin levels |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 5 | Pin index for configuration write and readback |
| cfg_wdata | input | 13 | Configuration word to write |
| cfg_rdata | output | 13 | Configuration word at cfg_idx |
| st_wr | input | 1 | Direct status write |
| st_set | input | 1 | Write-ones-to-set status alias |
| st_clr | input | 1 | Write-ones-to-clear status alias |
| st_wdata | input | 32 | Data for the status writes |
| level_o | output | 32 | Conditioned pin levels |
| raw_o | output | 32 | Unlatched detections this cycle |
| status_o | output | 32 | Sticky status vector |
| irq_vec_o | output | 32 | Status gated by maskable enables |
| nmi_vec_o | output | 32 | Status gated by non-maskable enables |
| irq_o | output | 1 | Maskable interrupt request |
| nmi_o | output | 1 | Non-maskable interrupt request |
| wake_o | output | 1 | Wakeup request |

## Verification
A configuration write and every status write take effect at the next rising edge. The status outputs, the interrupt vectors, the request lines and the wakeup line all follow from the status register with no further delay. A pin change reaches the conditioned level after zero edges in bypass, half a cycle in falling mode and one rising edge in rising mode, per stage. A detection appears on raw at once and in status one rising edge later. The bench drives its inputs 1 ns after a rising edge and samples there too, before it drives again. A cycle-level reference model updates on the same edges, so each comparison lands on the cycle in which the result is due. Directed checks with hand-computed values pin down the two-stage latencies and the clear-versus-detect collision.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // Per-stage synchronizer mode
    typedef enum logic [1:0] {
        SYNC_BYPASS   = 2'd0,
        SYNC_FALL     = 2'd1,
        SYNC_RISE     = 2'd2,
        SYNC_RISE_ALT = 2'd3
    } sync_mode_e;

    // Trigger selection of the detector
    typedef enum logic [2:0] {
        TRIG_OFF  = 3'd0,
        TRIG_RISE = 3'd1,
        TRIG_FALL = 3'd2,
        TRIG_ANY  = 3'd3,
        TRIG_LOW  = 3'd4,
        TRIG_HIGH = 3'd5,
        TRIG_RSV6 = 3'd6,
        TRIG_RSV7 = 3'd7
    } trig_mode_e;

    localparam int CFG_W = 13;

    // Per-pin configuration word, MSB first
    typedef struct packed {
        logic [4:0]  dest_en;   // [12:8] bit 8 maskable, bit 9 non-maskable
        logic        wake_en;   // [7]
        trig_mode_e  trig;      // [6:4]
        sync_mode_e  stage_b;   // [3:2] second stage
        sync_mode_e  stage_a;   // [1:0] first stage
    } pin_cfg_t;

endpackage

// File: rtl/gpio_sync_stage.sv
module gpio_sync_stage
    import gpio_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  sync_mode_e mode,
    input  logic       d,
    output logic       q
);

    logic q_rise;
    logic q_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_rise <= 1'b0;
        else        q_rise <= d;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) q_fall <= 1'b0;
        else        q_fall <= d;
    end

    always_comb begin
        unique case (mode)
            SYNC_BYPASS:              q = d;
            SYNC_FALL:                q = q_fall;
            SYNC_RISE, SYNC_RISE_ALT: q = q_rise;
            default:                  q = q_rise;
        endcase
    end

endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
    import gpio_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  trig_mode_e trig,
    input  logic       lvl,
    output logic       hit
);

    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    always_comb begin
        unique case (trig)
            TRIG_RISE:            hit = lvl & ~prev_q;
            TRIG_FALL:            hit = ~lvl & prev_q;
            TRIG_ANY:             hit = lvl ^ prev_q;
            TRIG_LOW:             hit = ~lvl;
            TRIG_HIGH:            hit = lvl;
            TRIG_OFF, TRIG_RSV6,
            TRIG_RSV7:            hit = 1'b0;
            default:              hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
    import gpio_irq_pkg::*;
#(
    parameter  int NPIN  = 30,
    localparam int IDX_W = $clog2(NPIN)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [IDX_W-1:0]        idx,
    input  logic [CFG_W-1:0]        wdata,
    output pin_cfg_t [NPIN-1:0]     cfg_o,
    output logic [CFG_W-1:0]        rdata
);

    for (genvar i = 0; i < NPIN; i++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cfg_o[i] <= '0;
            else if (we && idx == IDX_W'(i))
                cfg_o[i] <= pin_cfg_t'(wdata);
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NPIN; i++) begin
            if (idx == IDX_W'(i)) rdata = cfg_o[i];
        end
    end

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
    parameter int NPIN = 30
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] hit,
    input  logic            wr,
    input  logic            set,
    input  logic            clr,
    input  logic [NPIN-1:0] wdata,
    input  logic [NPIN-1:0] irq_en,
    input  logic [NPIN-1:0] nmi_en,
    input  logic [NPIN-1:0] wake_en,
    output logic [NPIN-1:0] status,
    output logic [NPIN-1:0] irq_vec,
    output logic [NPIN-1:0] nmi_vec,
    output logic            irq,
    output logic            nmi,
    output logic            wake
);

    logic [NPIN-1:0] status_nxt;

    // Order: direct write, set, clear, then detections win
    always_comb begin
        status_nxt = status;
        if (wr)  status_nxt = wdata;
        if (set) status_nxt = status_nxt | wdata;
        if (clr) status_nxt = status_nxt & ~wdata;
        status_nxt = status_nxt | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status <= '0;
        else        status <= status_nxt;
    end

    always_comb begin
        irq_vec = status & irq_en;
        nmi_vec = status & nmi_en;
        irq     = |irq_vec;
        nmi     = |nmi_vec;
        wake    = |(status & wake_en);
    end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter  int NPIN  = 30,
    parameter  int VEC_W = 32,
    localparam int IDX_W = $clog2(NPIN)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NPIN-1:0]     pin_i,
    input  logic                cfg_we,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic [CFG_W-1:0]    cfg_wdata,
    output logic [CFG_W-1:0]    cfg_rdata,
    input  logic                st_wr,
    input  logic                st_set,
    input  logic                st_clr,
    input  logic [VEC_W-1:0]    st_wdata,
    output logic [VEC_W-1:0]    level_o,
    output logic [VEC_W-1:0]    raw_o,
    output logic [VEC_W-1:0]    status_o,
    output logic [VEC_W-1:0]    irq_vec_o,
    output logic [VEC_W-1:0]    nmi_vec_o,
    output logic                irq_o,
    output logic                nmi_o,
    output logic                wake_o
);

    pin_cfg_t [NPIN-1:0] cfg;
    logic [NPIN-1:0]     stage_a_q;
    logic [NPIN-1:0]     lvl;
    logic [NPIN-1:0]     hit;
    logic [NPIN-1:0]     irq_en;
    logic [NPIN-1:0]     nmi_en;
    logic [NPIN-1:0]     wake_en;
    logic [NPIN-1:0]     status;
    logic [NPIN-1:0]     irq_vec;
    logic [NPIN-1:0]     nmi_vec;
    logic                unused_bits;

    gpio_cfg_bank #(.NPIN(NPIN)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .idx   (cfg_idx),
        .wdata (cfg_wdata),
        .cfg_o (cfg),
        .rdata (cfg_rdata)
    );

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        gpio_sync_stage u_stage_a (
            .clk   (clk),
            .rst_n (rst_n),
            .mode  (cfg[i].stage_a),
            .d     (pin_i[i]),
            .q     (stage_a_q[i])
        );

        gpio_sync_stage u_stage_b (
            .clk   (clk),
            .rst_n (rst_n),
            .mode  (cfg[i].stage_b),
            .d     (stage_a_q[i]),
            .q     (lvl[i])
        );

        gpio_trig_detect u_det (
            .clk   (clk),
            .rst_n (rst_n),
            .trig  (cfg[i].trig),
            .lvl   (lvl[i]),
            .hit   (hit[i])
        );

        assign irq_en[i]  = cfg[i].dest_en[0];
        assign nmi_en[i]  = cfg[i].dest_en[1];
        assign wake_en[i] = cfg[i].wake_en;
    end

    gpio_irq_status #(.NPIN(NPIN)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .wr      (st_wr),
        .set     (st_set),
        .clr     (st_clr),
        .wdata   (st_wdata[NPIN-1:0]),
        .irq_en  (irq_en),
        .nmi_en  (nmi_en),
        .wake_en (wake_en),
        .status  (status),
        .irq_vec (irq_vec),
        .nmi_vec (nmi_vec),
        .irq     (irq_o),
        .nmi     (nmi_o),
        .wake    (wake_o)
    );

    assign level_o   = VEC_W'(lvl);
    assign raw_o     = VEC_W'(hit);
    assign status_o  = VEC_W'(status);
    assign irq_vec_o = VEC_W'(irq_vec);
    assign nmi_vec_o = VEC_W'(nmi_vec);

    always_comb begin
        unused_bits = ^st_wdata;
        for (int i = 0; i < NPIN; i++) unused_bits = unused_bits ^ (^cfg[i].dest_en[4:2]);
    end

endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
    parameter int NPIN  = 30,
    parameter int VEC_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             st_wr,
    input logic             st_set,
    input logic             st_clr,
    input logic [VEC_W-1:0] st_wdata,
    input logic [VEC_W-1:0] raw_o,
    input logic [VEC_W-1:0] status_o,
    input logic [VEC_W-1:0] irq_vec_o,
    input logic             irq_o,
    input logic             nmi_o,
    input logic             wake_o
);

    localparam logic [VEC_W-1:0] MASK = {VEC_W{1'b1}} >> (VEC_W - NPIN);

    p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_o & ~MASK) == '0) && ((raw_o & ~MASK) == '0) && ((irq_vec_o & ~MASK) == '0));

    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_wr && !st_clr) |=> ((status_o & $past(status_o)) == $past(status_o)));

    p_set_alias_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_set && !st_wr && !st_clr) |=> ((status_o & $past(st_wdata) & MASK) == ($past(st_wdata) & MASK)));

    p_clear_alias_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_clr && !st_wr && !st_set) |=> ((status_o & $past(st_wdata) & ~$past(raw_o)) == '0));

    p_detect_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_o != '0) |=> ((status_o & $past(raw_o)) == $past(raw_o)));

    p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == '0) |-> (!irq_o && !nmi_o && !wake_o));

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPIN(NPIN), .VEC_W(VEC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_wr     (st_wr),
    .st_set    (st_set),
    .st_clr    (st_clr),
    .st_wdata  (st_wdata),
    .raw_o     (raw_o),
    .status_o  (status_o),
    .irq_vec_o (irq_vec_o),
    .irq_o     (irq_o),
    .nmi_o     (nmi_o),
    .wake_o    (wake_o)
);

// File: tb/sim_gpio_irq_bank.sv
`timescale 1ns/1ps
module sim_gpio_irq_bank;

    localparam int NP = 30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [NP-1:0] pin_i = '0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_idx = '0;
    logic [12:0] cfg_wdata = '0;
    logic [12:0] cfg_rdata;
    logic        st_wr = 1'b0, st_set = 1'b0, st_clr = 1'b0;
    logic [31:0] st_wdata = '0;
    logic [31:0] level_o, raw_o, status_o, irq_vec_o, nmi_vec_o;
    logic        irq_o, nmi_o, wake_o;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    gpio_irq_bank u0 (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .st_wr(st_wr), .st_set(st_set), .st_clr(st_clr), .st_wdata(st_wdata),
        .level_o(level_o), .raw_o(raw_o), .status_o(status_o),
        .irq_vec_o(irq_vec_o), .nmi_vec_o(nmi_vec_o),
        .irq_o(irq_o), .nmi_o(nmi_o), .wake_o(wake_o)
    );

    // ---------------- reference model ----------------
    logic [12:0]   m_cfg [NP];
    logic [NP-1:0] ma_r, ma_f, mb_r, mb_f, m_prev, m_stat;
    logic [NP-1:0] m_a, m_lvl, m_raw, e_irq, e_nmi, e_wake;

    function automatic logic f_stage(input logic [1:0] md, input logic d, input logic r, input logic f);
        if (md == 2'd0) return d;
        if (md == 2'd1) return f;
        return r;
    endfunction

    function automatic logic f_trig(input logic [2:0] t, input logic l, input logic p);
        case (t)
            3'd1: return l & ~p;
            3'd2: return ~l & p;
            3'd3: return l ^ p;
            3'd4: return ~l;
            3'd5: return l;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [NP-1:0] f_next(input logic [NP-1:0] s, input logic w, input logic st,
                                            input logic c, input logic [NP-1:0] d, input logic [NP-1:0] h);
        logic [NP-1:0] n;
        n = s;
        if (w)  n = d;
        if (st) n = n | d;
        if (c)  n = n & ~d;
        return n | h;
    endfunction

    always_comb begin
        for (int i = 0; i < NP; i++) begin
            m_a[i]    = f_stage(m_cfg[i][1:0], pin_i[i], ma_r[i], ma_f[i]);
            m_lvl[i]  = f_stage(m_cfg[i][3:2], m_a[i], mb_r[i], mb_f[i]);
            m_raw[i]  = f_trig(m_cfg[i][6:4], m_lvl[i], m_prev[i]);
            e_irq[i]  = m_stat[i] & m_cfg[i][8];
            e_nmi[i]  = m_stat[i] & m_cfg[i][9];
            e_wake[i] = m_stat[i] & m_cfg[i][7];
        end
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ma_r <= '0; mb_r <= '0; m_prev <= '0; m_stat <= '0;
            for (int i = 0; i < NP; i++) m_cfg[i] <= '0;
        end else begin
            ma_r   <= pin_i;
            mb_r   <= m_a;
            m_prev <= m_lvl;
            m_stat <= f_next(m_stat, st_wr, st_set, st_clr, st_wdata[NP-1:0], m_raw);
            if (cfg_we && cfg_idx < 5'(NP)) m_cfg[cfg_idx] <= cfg_wdata;
        end
    end

    always @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ma_f <= '0; mb_f <= '0;
        end else begin
            ma_f <= pin_i;
            mb_f <= m_a;
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        chk(tag,   "status",   status_o,  32'(m_stat));
        chk("R6",  "raw",      raw_o,     32'(m_raw));
        chk("R2",  "level",    level_o,   32'(m_lvl));
        chk("R11", "irq_vec",  irq_vec_o, 32'(e_irq));
        chk("R11", "nmi_vec",  nmi_vec_o, 32'(e_nmi));
        chk("R11", "irq",      32'(irq_o), 32'(|e_irq));
        chk("R11", "nmi",      32'(nmi_o), 32'(|e_nmi));
        chk("R12", "wake",     32'(wake_o), 32'(|e_wake));
        chk("R14", "cfg_rd",   32'(cfg_rdata), (cfg_idx < 5'(NP)) ? 32'(m_cfg[cfg_idx]) : 32'd0);
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        #1;
        compare_all(tag);
    endtask

    task automatic cfg_write(input int idx, input logic [12:0] d);
        cfg_we = 1'b1; cfg_idx = 5'(idx); cfg_wdata = d;
        step("R14");
        cfg_we = 1'b0;
    endtask

    task automatic st_op(input logic w, input logic s, input logic c, input logic [31:0] d, input string tag);
        st_wr = w; st_set = s; st_clr = c; st_wdata = d;
        step(tag);
        st_wr = 1'b0; st_set = 1'b0; st_clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        // R13 reset state
        repeat (2) begin
            @(posedge clk); #1;
            compare_all("R13");
            chk("R13", "status_rst", status_o, 32'd0);
        end
        rst_n = 1'b1;
        step("R13");
        chk("R13", "status_after", status_o, 32'd0);
        chk("R13", "cfg_after", 32'(cfg_rdata), 32'd0);

        // R14 config readback, out of range index
        cfg_write(3, 13'h1ABC);
        chk("R14", "cfg3", 32'(cfg_rdata), 32'h1ABC);
        cfg_idx = 5'd30; step("R14");
        chk("R14", "cfg30", 32'(cfg_rdata), 32'd0);
        cfg_idx = 5'd31; step("R14");

        // R2 stage latencies, trig any; modes (b,a): pin0 rise/rise, pin1 bypass, pin2 fall/fall, pin3 a=fall b=rise
        cfg_write(0, 13'h03A);
        cfg_write(1, 13'h030);
        cfg_write(2, 13'h035);
        cfg_write(3, 13'h039);
        repeat (3) step("R2");
        pin_i[3:0] = 4'hF;
        step("R2");
        chk("R2", "lat1", 32'(level_o[3:0]), 32'hA);
        step("R2");
        chk("R2", "lat2", 32'(level_o[3:0]), 32'hF);
        repeat (2) step("R2");

        // R3 / R10: pin5 level high, pin6 rising edge, both bypass
        cfg_write(5, 13'h050);
        cfg_write(6, 13'h010);
        st_op(1'b1, 1'b0, 1'b0, 32'd0, "R7");
        pin_i[6:5] = 2'b11;
        repeat (3) step("R3");
        st_op(1'b0, 1'b0, 1'b1, 32'h60, "R10");
        step("R3");
        chk("R3", "edge_once", 32'(status_o[6]), 32'd0);
        chk("R10", "detect_wins", 32'(status_o[5]), 32'd1);
        pin_i[6] = 1'b0; step("R3");
        pin_i[6] = 1'b1; step("R3");
        chk("R3", "edge_again", 32'(status_o[6]), 32'd1);

        // R4 level low persists: pin8 trig low, held low
        cfg_write(8, 13'h040);
        repeat (3) begin
            st_op(1'b0, 1'b0, 1'b1, 32'h100, "R4");
            step("R4");
            chk("R4", "relevel", 32'(status_o[8]), 32'd1);
        end

        // R5 off and unused codes never detect
        cfg_write(7, 13'h000);
        cfg_write(9, 13'h060);
        cfg_write(8, 13'h070);
        st_op(1'b1, 1'b0, 1'b0, 32'd0, "R5");
        repeat (4) begin
            pin_i[9:7] = ~pin_i[9:7];
            step("R5");
            chk("R5", "no_raw", 32'(raw_o[9:7]), 32'd0);
        end
        chk("R5", "no_status", 32'(status_o[9:7]), 32'd0);

        // R7/R8/R9 with every detector off
        for (int i = 0; i < NP; i++) cfg_write(i, 13'h000);
        pin_i = '0;
        st_op(1'b1, 1'b0, 1'b0, 32'hFFFF_0F0F, "R7");
        chk("R7", "direct", status_o, 32'h3FFF_0F0F);
        chk("R1", "upper", status_o & 32'hC000_0000, 32'd0);
        st_op(1'b0, 1'b1, 1'b0, 32'h0000_F000, "R8");
        chk("R8", "set", status_o, 32'h3FFF_FF0F);
        st_op(1'b0, 1'b0, 1'b1, 32'h0F0F_0001, "R9");
        chk("R9", "clear", status_o, 32'h30F0_FF0E);

        // R11/R12 destinations and wakeup
        cfg_write(4, 13'h100);
        cfg_write(12, 13'h200);
        cfg_write(20, 13'h080);
        cfg_write(25, 13'h1C00);
        st_op(1'b1, 1'b0, 1'b0, 32'h0210_1010, "R11");
        chk("R11", "irqv", irq_vec_o, 32'h0000_0010);
        chk("R11", "nmiv", nmi_vec_o, 32'h0000_1000);
        chk("R11", "lines", {29'd0, irq_o, nmi_o, wake_o}, 32'd7);
        st_op(1'b0, 1'b0, 1'b1, 32'h0010_0000, "R12");
        chk("R12", "wake_off", 32'(wake_o), 32'd0);
        st_op(1'b1, 1'b0, 1'b0, 32'h0200_0000, "R11");
        chk("R11", "unused_en", {29'd0, irq_o, nmi_o, wake_o}, 32'd0);

        // Random phase against the model
        for (int i = 0; i < NP; i++) cfg_write(i, 13'($urandom));
        for (int c = 0; c < 3000; c++) begin
            int r;
            if (c % 50 == 0) begin
                cfg_we = 1'b1; cfg_idx = 5'($urandom % 32); cfg_wdata = 13'($urandom);
            end else begin
                cfg_we = 1'b0; cfg_idx = 5'($urandom % 32);
            end
            pin_i = pin_i ^ (NP'($urandom) & NP'($urandom));
            r = int'($urandom % 16);
            st_wr = (r == 0); st_set = (r == 1 || r == 3); st_clr = (r == 2 || r == 3);
            st_wdata = $urandom;
            step("R3");
        end
        cfg_we = 1'b0; st_wr = 1'b0; st_set = 1'b0; st_clr = 1'b0;
        step("R3");

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule